// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor. It holds a control address register and a control store of microwords. Each microword is presented directly as an 18-bit control bus and a 4-bit ALU operation select. Three of the control bits steer the sequencer itself: step the control address by one, jump to the routine for the current opcode, or clear to address zero. The datapath it drives is a separate block. That datapath holds the program counter, memory address and buffer registers, the instruction register, the operand register and the accumulator.

Every instruction starts with the same four-word fetch routine. Fetch ends by jumping to the routine chosen by the opcode from the instruction register. Each routine ends on a word that clears the control address, so the next fetch begins on the following clock. The conditional jump routine uses the accumulator sign input to decide whether to load the program counter. The halt routine parks on an idle word until reset.

Top module: `mseq_sequencer`

## Requirements
- R1: Reset is synchronous and active-high. While it is asserted, and in the first cycle after it is released, `ctl` is 0x00801 and `alu_sel` is 0. Reset taken in the middle of a routine restarts at that fetch word.
- R2: The fetch routine issues `ctl` = 0x00801, 0x00049, 0x01081, 0x00102 on four consecutive cycles, with `alu_sel` = 0. The bits stand for: 11 = address from PC, 0 = step; 3 = read, 6 = buffer from memory; 7 = IR load, 12 = PC increment; 8 = address from buffer, 1 = opcode jump.
- R3: The opcode is used only at the clock edge that ends fetch word 0x00102. Changes at other times do not alter the routine that runs. Opcodes: ADD 0x01, SUB 0x02, AND 0x03, OR 0x04, NOT 0x05, SHIFTR 0x06, SHIFTL 0x07, MPY 0x08, DIV 0x09, JMPGEZ 0x0A, JMP 0x0B, HALT 0x0C, STORE 0x0D, LOAD 0x0E.
- R4: ADD, SUB, AND, OR, NOT, MPY and DIV run the same four words: 0x00049, 0x00201, 0x06001, 0x08004. On the 0x06001 word, `alu_sel` is the operation code: ADD 1, SUB 2, AND 3, OR 4, NOT 5, MPY 8, DIV 9. On every other word `alu_sel` is 0.
- R5: SHIFTR and SHIFTL run two words, 0x04001 and then 0x08004. `alu_sel` is 6 or 7 on the first word.
- R6: LOAD runs 0x00049, 0x00201, 0x10004. STORE runs 0x20001, 0x00034.
- R7: JMP runs one word, 0x00404. JMPGEZ runs one word that is 0x00404 when `acc_sign` is 0 and 0x00004 when it is 1, both in the same cycle.
- R8: HALT parks on `ctl` = 0 and `alu_sel` = 0, whatever `opcode` and `acc_sign` do, until reset.
- R9: Any opcode not listed in R3 runs the single word 0x00004.
- R10: In the cycle after any word with bit 2 set, `ctl` is 0x00801.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W (8) | Opcode field from the instruction register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| ctl | output | 18 | Control bus of the current microword |
| alu_sel | output | 4 | ALU operation select of the current microword |

## Verification
A microword is chosen at a rising edge and stays on `ctl` and `alu_sel` until the next rising edge. The one exception is the conditional program-counter bit of JMPGEZ, which follows `acc_sign` within the same cycle. The bench therefore drives inputs and samples outputs on the falling edge, and advances exactly one word per falling edge. The opcode counts only at the edge after the 0x00102 word. The bench shows this by changing the opcode at the falling edge just after that edge and checking that the routine already started is unchanged. A reset asserted at a falling edge is expected to show the first fetch word at the next falling edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int CS_W  = 18;
  localparam int ALU_W = 4;

  // control bit positions (fixed meanings)
  localparam int B_CAR_INC = 0;
  localparam int B_CAR_MAP = 1;
  localparam int B_CAR_CLR = 2;
  localparam int B_MEM_RD  = 3;
  localparam int B_MB2MEM  = 4;
  localparam int B_MEM_WR  = 5;
  localparam int B_MEM2MB  = 6;
  localparam int B_IR_LD   = 7;
  localparam int B_MAR_MB  = 8;
  localparam int B_BR_LD   = 9;
  localparam int B_PC_LD   = 10;
  localparam int B_MAR_PC  = 11;
  localparam int B_PC_INC  = 12;
  localparam int B_ALU_BR  = 13;
  localparam int B_ALU_ACC = 14;
  localparam int B_ACC_ALU = 15;
  localparam int B_ACC_BR  = 16;
  localparam int B_MB_ACC  = 17;

  // ALU select codes
  localparam logic [ALU_W-1:0] ALU_SHR = 4'd6;
  localparam logic [ALU_W-1:0] ALU_SHL = 4'd7;

  // opcodes
  localparam int OP_JGEZ  = 'h0A;
  localparam int OP_JMP   = 'h0B;
  localparam int OP_HALT  = 'h0C;
  localparam int OP_STORE = 'h0D;
  localparam int OP_LOAD  = 'h0E;

  // control store layout
  localparam int A_HALT  = 4;
  localparam int A_ILL   = 5;
  localparam int A_JMP   = 6;
  localparam int A_JGEZ  = 7;
  localparam int A_LOAD  = 8;
  localparam int A_STORE = 11;
  localparam int A_SHR   = 13;
  localparam int A_SHL   = 15;
  localparam int A_BIN   = 17;
  localparam int N_BIN   = 7;
  localparam int N_USED  = A_BIN + 4 * N_BIN;

  typedef struct packed {
    logic             cond;  // PC load gated by accumulator sign
    logic [ALU_W-1:0] alu;
    logic [CS_W-1:0]  cs;
  } mword_t;

  function automatic logic [CS_W-1:0] bt(input int i);
    return CS_W'(1) << i;
  endfunction

  // ALU code of binary routine k (0..6): ADD SUB AND OR NOT MPY DIV
  function automatic logic [ALU_W-1:0] bin_code(input int k);
    return (k < 5) ? ALU_W'(k + 1) : ALU_W'(k + 3);
  endfunction

  function automatic mword_t micro_word(input int a);
    mword_t w;
    int     k;
    int     ph;
    w = '0;
    if (a == 0)            w.cs = bt(B_MAR_PC) | bt(B_CAR_INC);
    else if (a == 1)       w.cs = bt(B_MEM_RD) | bt(B_MEM2MB) | bt(B_CAR_INC);
    else if (a == 2)       w.cs = bt(B_IR_LD) | bt(B_PC_INC) | bt(B_CAR_INC);
    else if (a == 3)       w.cs = bt(B_MAR_MB) | bt(B_CAR_MAP);
    else if (a == A_HALT)  w.cs = '0;
    else if (a == A_ILL)   w.cs = bt(B_CAR_CLR);
    else if (a == A_JMP)   w.cs = bt(B_PC_LD) | bt(B_CAR_CLR);
    else if (a == A_JGEZ) begin
      w.cond = 1'b1;
      w.cs   = bt(B_CAR_CLR);
    end
    else if (a == A_LOAD)      w.cs = bt(B_MEM_RD) | bt(B_MEM2MB) | bt(B_CAR_INC);
    else if (a == A_LOAD + 1)  w.cs = bt(B_BR_LD) | bt(B_CAR_INC);
    else if (a == A_LOAD + 2)  w.cs = bt(B_ACC_BR) | bt(B_CAR_CLR);
    else if (a == A_STORE)     w.cs = bt(B_MB_ACC) | bt(B_CAR_INC);
    else if (a == A_STORE + 1) w.cs = bt(B_MB2MEM) | bt(B_MEM_WR) | bt(B_CAR_CLR);
    else if (a == A_SHR || a == A_SHL) begin
      w.cs  = bt(B_ALU_ACC) | bt(B_CAR_INC);
      w.alu = (a == A_SHR) ? ALU_SHR : ALU_SHL;
    end
    else if (a == A_SHR + 1 || a == A_SHL + 1) w.cs = bt(B_ACC_ALU) | bt(B_CAR_CLR);
    else if (a >= A_BIN && a < N_USED) begin
      k  = (a - A_BIN) / 4;
      ph = (a - A_BIN) % 4;
      case (ph)
        0: w.cs = bt(B_MEM_RD) | bt(B_MEM2MB) | bt(B_CAR_INC);
        1: w.cs = bt(B_BR_LD) | bt(B_CAR_INC);
        2: begin
          w.cs  = bt(B_ALU_BR) | bt(B_ALU_ACC) | bt(B_CAR_INC);
          w.alu = bin_code(k);
        end
        default: w.cs = bt(B_ACC_ALU) | bt(B_CAR_CLR);
      endcase
    end
    else w.cs = bt(B_CAR_CLR);
    return w;
  endfunction

  // routine start address for an opcode value
  function automatic int start_of(input int op);
    int s;
    case (op)
      'h01, 'h02, 'h03, 'h04, 'h05: s = A_BIN + 4 * (op - 1);
      'h08, 'h09:                   s = A_BIN + 4 * (op - 3);
      'h06:                         s = A_SHR;
      'h07:                         s = A_SHL;
      OP_JGEZ:                      s = A_JGEZ;
      OP_JMP:                       s = A_JMP;
      OP_HALT:                      s = A_HALT;
      OP_STORE:                     s = A_STORE;
      OP_LOAD:                      s = A_LOAD;
      default:                      s = A_ILL;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mseq_opmap.sv
module mseq_opmap #(
  parameter int OPC_W = 8,
  parameter int AW    = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [AW-1:0]    start
);
  localparam int N_OPS = 16;

  logic [N_OPS-1:0] hit;

  // decode the defined opcode range; anything else is illegal
  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_dec
      assign hit[g] = (opcode == OPC_W'(g));
    end
  endgenerate

  always_comb begin
    start = AW'(mseq_pkg::A_ILL);
    for (int i = 0; i < N_OPS; i++)
      if (hit[i]) start = AW'(mseq_pkg::start_of(i));
  end
endmodule

// File: rtl/mseq_nextaddr.sv
module mseq_nextaddr #(
  parameter int AW = 6
) (
  input  logic [AW-1:0] car,
  input  logic          inc,
  input  logic          jmp,
  input  logic          clr,
  input  logic [AW-1:0] map_addr,
  output logic [AW-1:0] nxt
);
  // priority: clear, opcode jump, step, else hold
  always_comb begin
    if (clr)      nxt = '0;
    else if (jmp) nxt = map_addr;
    else if (inc) nxt = car + AW'(1);
    else          nxt = car;
  end
endmodule

// File: rtl/mseq_cstore.sv
module mseq_cstore #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output mseq_pkg::mword_t     word
);
  mseq_pkg::mword_t rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = mseq_pkg::micro_word(i);
  end

  // registered read: the stored word is also the control buffer
  always_ff @(posedge clk) word <= rom[addr];
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer #(
  parameter int OPC_W    = 8,
  parameter int CM_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc_sign,
  output logic [17:0]      ctl,
  output logic [3:0]       alu_sel
);
  import mseq_pkg::*;

  localparam int AW = $clog2(CM_DEPTH);
  localparam logic [CS_W-1:0] FETCH0 = bt(B_MAR_PC) | bt(B_CAR_INC);
  localparam logic [CS_W-1:0] FETCH1 = bt(B_MEM_RD) | bt(B_MEM2MB) | bt(B_CAR_INC);

  mword_t        word;
  logic [AW-1:0] car_q;
  logic [AW-1:0] map_addr;
  logic [AW-1:0] nxt;
  logic [AW-1:0] rd_addr;

  mseq_opmap #(.OPC_W(OPC_W), .AW(AW)) u_map (
    .opcode (opcode),
    .start  (map_addr)
  );

  mseq_nextaddr #(.AW(AW)) u_next (
    .car      (car_q),
    .inc      (word.cs[B_CAR_INC]),
    .jmp      (word.cs[B_CAR_MAP]),
    .clr      (word.cs[B_CAR_CLR]),
    .map_addr (map_addr),
    .nxt      (nxt)
  );

  assign rd_addr = rst ? '0 : nxt;

  always_ff @(posedge clk) car_q <= rd_addr;

  mseq_cstore #(.DEPTH(CM_DEPTH), .AW(AW)) u_cm (
    .clk  (clk),
    .addr (rd_addr),
    .word (word)
  );

  assign ctl     = word.cs | (CS_W'(word.cond & ~acc_sign) << B_PC_LD);
  assign alu_sel = word.alu;

  // R10: a clearing word is always followed by the first fetch word
  a_r10_clear_to_fetch: assert property (@(posedge clk) disable iff (rst)
    word.cs[B_CAR_CLR] |=> (ctl == FETCH0));

  // R2: fetch word 0 is followed by the memory read word
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (word.cs == FETCH0) |=> (word.cs == FETCH1));

  // R8: the idle word holds until reset
  a_r8_halt_park: assert property (@(posedge clk) disable iff (rst)
    (word == '0) |=> (word == '0 && ctl == '0));

  // R4: an ALU code is only issued while the accumulator is gated in
  a_r4_alu_gated: assert property (@(posedge clk) disable iff (rst)
    (word.alu != '0) |-> word.cs[B_ALU_ACC]);

  // R7: the sign-gated word clears and never steps
  a_r7_cond_returns: assert property (@(posedge clk) disable iff (rst)
    word.cond |-> (word.cs[B_CAR_CLR] && !word.cs[B_CAR_INC] && !word.cs[B_PC_LD]));

  // R3: at most one sequencing bit per word
  a_r3_one_seq: assert property (@(posedge clk) disable iff (rst)
    $onehot0(word.cs[2:0]));
endmodule

// File: tb/mseq_sequencer_bench.sv
`timescale 1ns/1ps
module mseq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic        acc_sign = 1'b0;
  logic [17:0] ctl;
  logic [3:0]  alu_sel;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mseq_sequencer u_mseq_sequencer (
    .clk (clk), .rst (rst), .opcode (opcode), .acc_sign (acc_sign),
    .ctl (ctl), .alu_sel (alu_sel)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        sg;
    logic [3:0]  n;
    logic [17:0] first;
    logic [3:0]  alu;
    logic [17:0] last;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b0, 4'd4, 18'h00049, 4'd1, 18'h08004},
    '{8'h02, 1'b1, 4'd4, 18'h00049, 4'd2, 18'h08004},
    '{8'h03, 1'b0, 4'd4, 18'h00049, 4'd3, 18'h08004},
    '{8'h04, 1'b1, 4'd4, 18'h00049, 4'd4, 18'h08004},
    '{8'h05, 1'b0, 4'd4, 18'h00049, 4'd5, 18'h08004},
    '{8'h08, 1'b1, 4'd4, 18'h00049, 4'd8, 18'h08004},
    '{8'h09, 1'b0, 4'd4, 18'h00049, 4'd9, 18'h08004},
    '{8'h06, 1'b0, 4'd2, 18'h04001, 4'd6, 18'h08004},
    '{8'h07, 1'b1, 4'd2, 18'h04001, 4'd7, 18'h08004},
    '{8'h0E, 1'b1, 4'd3, 18'h00049, 4'd0, 18'h10004},
    '{8'h0D, 1'b0, 4'd2, 18'h20001, 4'd0, 18'h00034},
    '{8'h0B, 1'b1, 4'd1, 18'h00404, 4'd0, 18'h00404},
    '{8'h0A, 1'b0, 4'd1, 18'h00404, 4'd0, 18'h00404},
    '{8'h0A, 1'b1, 4'd1, 18'h00004, 4'd0, 18'h00004},
    '{8'hFF, 1'b0, 4'd1, 18'h00004, 4'd0, 18'h00004},
    '{8'h00, 1'b1, 4'd1, 18'h00004, 4'd0, 18'h00004}
  };

  localparam logic [17:0] FETCH [4] = '{18'h00801, 18'h00049, 18'h01081, 18'h00102};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h06, 8'h07: return "R5";
      8'h0D, 8'h0E: return "R6";
      8'h0A, 8'h0B: return "R7";
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09: return "R4";
      default: return "R9";
    endcase
  endfunction

  // entered at the falling edge showing fetch word 0
  task automatic do_fetch(input logic [7:0] op, input logic sg);
    opcode = op;
    acc_sign = sg;
    for (int k = 0; k < 4; k++) begin
      check("R2 fetch word", ctl, FETCH[k]);
      check("R2 fetch alu", alu_sel, 0);
      @(negedge clk);
    end
  endtask

  task automatic do_exec(input string req, input logic [3:0] n, input logic [17:0] first,
                         input logic [17:0] last, input logic [3:0] alu,
                         input bit swap, input logic [7:0] swap_op);
    int cnt = 0;
    logic [3:0] seen = '0;
    bit done = 0;
    if (swap) opcode = swap_op;  // R3: too late to matter
    for (int s = 0; s < 8 && !done; s++) begin
      if (s == 0) check({req, " first word"}, ctl, first);
      if (ctl[14]) seen = alu_sel;
      cnt++;
      if (ctl[2]) begin
        check({req, " last word"}, ctl, last);
        done = 1;
      end
      @(negedge clk);
    end
    check({req, " routine length"}, cnt, n);
    check({req, " alu select"}, seen, alu);
    check("R10 next fetch", ctl, 18'h00801);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset ctl", ctl, 18'h00801);
    check("R1 reset alu", alu_sel, 0);
    rst = 1'b0;
    check("R1 first cycle after release", ctl, 18'h00801);

    // table of routines
    for (int v = 0; v < NV; v++) begin
      do_fetch(VECS[v].op, VECS[v].sg);
      do_exec(tag_of(VECS[v].op), VECS[v].n, VECS[v].first, VECS[v].last,
              VECS[v].alu, 1'b0, 8'h00);
    end

    // R3: opcode changed after the mapping edge has no effect
    do_fetch(8'h01, 1'b0);
    do_exec("R3 late opcode change", 4'd4, 18'h00049, 18'h08004, 4'd1, 1'b1, 8'h0B);

    // R7: sign toggled within the conditional word
    do_fetch(8'h0A, 1'b1);
    check("R7 sign 1", ctl, 18'h00004);
    acc_sign = 1'b0;
    #0.5;
    check("R7 sign 0 same cycle", ctl, 18'h00404);
    @(negedge clk);
    check("R10 after cond jump", ctl, 18'h00801);

    // R8: halt parks regardless of inputs
    do_fetch(8'h0C, 1'b0);
    for (int c = 0; c < 12; c++) begin
      check("R8 halt ctl", ctl, 18'h00000);
      check("R8 halt alu", alu_sel, 0);
      opcode = 8'(c * 7 + 1);
      acc_sign = c[0];
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset leaves halt", ctl, 18'h00801);
    rst = 1'b0;

    // R1: reset in the middle of a routine
    do_fetch(8'h0E, 1'b0);
    check("R6 load first word", ctl, 18'h00049);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-routine reset", ctl, 18'h00801);
    rst = 1'b0;
    do_fetch(8'h0B, 1'b0);
    do_exec("R7 after reset", 4'd1, 18'h00404, 18'h00404, 4'd0, 1'b0, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule